// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Aggregator

The block watches a bank of general-purpose input lines, 76 by default, and turns a selected edge on any of them into a latched pending bit. Software chooses rising or falling detection for each line, and can hide a line from the interrupt output without losing its events. All unmasked pending bits are ORed into one interrupt wire that feeds a parent interrupt controller.

Software reaches the block through a small register port with 16-bit data. There are four banks: mask, acknowledge, edge type and status. Each bank holds one bit per line, packed sixteen lines to a word, and the words of a bank sit at a 4-byte address stride. When the interrupt fires, software scans the status words to find the lines that raised it. It then clears each of those lines by writing a one to the matching acknowledge bit.

Top module: `edge_irq_aggregator`

## Requirements
- R1: After reset every line is masked (mask words read 0xFFFF, and the top word reads 0x0FFF), every line detects rising edges (type words read 0), no line is pending and `irq_out` is low.
- R2: With its type bit at 0, a 0-to-1 transition on a line sets its pending bit, and a 1-to-0 transition does not.
- R3: With its type bit at 1, a 1-to-0 transition on a line sets its pending bit, and a 0-to-1 transition does not.
- R4: Line n maps to word n/16, bit n%16, of every bank. The word of a bank is at bank base + 4*(n/16). The bases are 0x00 for mask, 0x28 for acknowledge, 0x40 for type and 0xC0 for status. Five words are decoded per bank. Unaligned or unmapped addresses read 0.
- R5: A mask bit at 1 hides the line from status and from `irq_out`. An edge on a masked line still sets its pending bit, and that bit appears in status once the line is unmasked. A status bit reads as pending AND NOT mask.
- R6: Writing 1 to an acknowledge bit clears that line's pending bit on the next clock. Writing 0 to it has no effect. The acknowledge words read 0.
- R7: When an acknowledge write and a newly detected edge hit the same line in the same cycle, the line stays pending.
- R8: `irq_out` is high exactly when at least one status bit is set.
- R9: Bits 12 to 15 of the fifth word of each bank read 0 and ignore writes. Writes to the status bank change nothing.
- R10: An input transition reaches the status bank on the third rising clock edge after it is applied. The status bit is still clear after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | 76 | Asynchronous input lines |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Aggregated interrupt toward the parent controller |

## Verification
The assertions assume that the input lines are low when reset is released. A line held high at that moment would look like a rising edge against the cleared history register. They also assume that a register write lasts exactly one cycle, so that an acknowledge pulse cannot overlap a second pulse. The stimulus holds every input at 0 through reset, changes inputs and register signals only on falling clock edges, and drops `reg_wr` after one cycle. It sweeps every one of the 76 lines in both polarities, and each line's expected status word is computed as 1 << (n%16) at word n/16.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    localparam int WORD_W      = 16;
    localparam int ADDR_W      = 8;
    localparam int WORD_STRIDE = 4;

    localparam int MASK_BASE   = 'h00;
    localparam int ACK_BASE    = 'h28;
    localparam int TYPE_BASE   = 'h40;
    localparam int STATUS_BASE = 'hC0;

    typedef enum logic [1:0] {
        BANK_MASK   = 2'd0,
        BANK_ACK    = 2'd1,
        BANK_TYPE   = 2'd2,
        BANK_STATUS = 2'd3
    } bank_e;

    typedef struct packed {
        logic       hit;
        bank_e      bank;
        logic [7:0] word;
    } reg_sel_t;

    function automatic logic in_bank(input int a, input int base, input int num_words);
        return (a >= base) && (a < base + num_words * WORD_STRIDE);
    endfunction

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] addr,
                                             input int num_words);
        reg_sel_t s;
        int a;
        a = int'(addr);
        s = '0;
        if (addr[1:0] == 2'b00) begin
            if (in_bank(a, MASK_BASE, num_words)) begin
                s.hit = 1'b1; s.bank = BANK_MASK;
                s.word = 8'((a - MASK_BASE) / WORD_STRIDE);
            end else if (in_bank(a, ACK_BASE, num_words)) begin
                s.hit = 1'b1; s.bank = BANK_ACK;
                s.word = 8'((a - ACK_BASE) / WORD_STRIDE);
            end else if (in_bank(a, TYPE_BASE, num_words)) begin
                s.hit = 1'b1; s.bank = BANK_TYPE;
                s.word = 8'((a - TYPE_BASE) / WORD_STRIDE);
            end else if (in_bank(a, STATUS_BASE, num_words)) begin
                s.hit = 1'b1; s.bank = BANK_STATUS;
                s.word = 8'((a - STATUS_BASE) / WORD_STRIDE);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 76,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= async_in;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int NUM_LINES = 76
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] line_sync,
    input  logic [NUM_LINES-1:0] falling_sel,
    input  logic [NUM_LINES-1:0] ack_pulse,
    output logic [NUM_LINES-1:0] edge_hit,
    output logic [NUM_LINES-1:0] pending
);

    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] pend_q;

    always_comb begin
        for (int n = 0; n < NUM_LINES; n++) begin
            edge_hit[n] = falling_sel[n] ? (prev_q[n] & ~line_sync[n])
                                         : (~prev_q[n] & line_sync[n]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= line_sync;
            pend_q <= (pend_q & ~ack_pulse) | edge_hit;
        end
    end

    assign pending = pend_q;

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import edge_irq_pkg::*;
#(
    parameter int NUM_LINES = 76
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] pending,
    output logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] falling_sel,
    output logic [NUM_LINES-1:0] ack_pulse,
    output logic [NUM_LINES-1:0] status
);

    localparam int NUM_WORDS = (NUM_LINES + WORD_W - 1) / WORD_W;
    localparam int PAD_W     = NUM_WORDS * WORD_W;

    reg_sel_t             sel;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] type_q;
    logic [PAD_W-1:0]     mask_pad;
    logic [PAD_W-1:0]     type_pad;
    logic [PAD_W-1:0]     status_pad;

    assign sel = decode_addr(reg_addr, NUM_WORDS);

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        localparam int W = n / WORD_W;
        localparam int B = n % WORD_W;
        logic word_wr;
        assign word_wr = reg_wr && sel.hit && (sel.word == 8'(W));

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[n] <= 1'b1;
                type_q[n] <= 1'b0;
            end else begin
                if (word_wr && sel.bank == BANK_MASK) mask_q[n] <= reg_wdata[B];
                if (word_wr && sel.bank == BANK_TYPE) type_q[n] <= reg_wdata[B];
            end
        end

        assign ack_pulse[n] = word_wr && (sel.bank == BANK_ACK) && reg_wdata[B];
    end

    assign status      = pending & ~mask_q;
    assign mask        = mask_q;
    assign falling_sel = type_q;

    always_comb begin
        mask_pad   = '0;
        type_pad   = '0;
        status_pad = '0;
        mask_pad[NUM_LINES-1:0]   = mask_q;
        type_pad[NUM_LINES-1:0]   = type_q;
        status_pad[NUM_LINES-1:0] = status;
    end

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (sel.hit && sel.word == 8'(w)) begin
                unique case (sel.bank)
                    BANK_MASK:   reg_rdata = mask_pad[w*WORD_W +: WORD_W];
                    BANK_TYPE:   reg_rdata = type_pad[w*WORD_W +: WORD_W];
                    BANK_STATUS: reg_rdata = status_pad[w*WORD_W +: WORD_W];
                    BANK_ACK:    reg_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/edge_irq_aggregator.sv
module edge_irq_aggregator
    import edge_irq_pkg::*;
#(
    parameter int NUM_LINES   = 76,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] gpio_in,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 irq_out
);

    logic [NUM_LINES-1:0] sync_w;
    logic [NUM_LINES-1:0] mask_w;
    logic [NUM_LINES-1:0] falling_w;
    logic [NUM_LINES-1:0] ack_w;
    logic [NUM_LINES-1:0] edge_w;
    logic [NUM_LINES-1:0] pending_w;
    logic [NUM_LINES-1:0] status_w;

    irq_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (gpio_in),
        .sync_out (sync_w)
    );

    irq_edge_latch #(
        .NUM_LINES (NUM_LINES)
    ) u_latch (
        .clk         (clk),
        .rst         (rst),
        .line_sync   (sync_w),
        .falling_sel (falling_w),
        .ack_pulse   (ack_w),
        .edge_hit    (edge_w),
        .pending     (pending_w)
    );

    irq_regfile #(
        .NUM_LINES (NUM_LINES)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .pending     (pending_w),
        .mask        (mask_w),
        .falling_sel (falling_w),
        .ack_pulse   (ack_w),
        .status      (status_w)
    );

    assign irq_out = |status_w;

endmodule

// File: rtl/edge_irq_checker.sv
module edge_irq_checker #(
    parameter int NUM_LINES = 76
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] mask,
    input logic [NUM_LINES-1:0] ack,
    input logic [NUM_LINES-1:0] edge_hit,
    input logic [NUM_LINES-1:0] pending,
    input logic                 irq_out
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((&mask) && (pending == '0) && !irq_out));

    assert_no_spurious_pending_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pending & ~$past(pending) & ~$past(edge_hit)) == '0));

    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (&mask) |-> !irq_out);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pending & $past(ack & ~edge_hit)) == '0));

    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pending & $past(edge_hit)) == $past(edge_hit)));

    assert_unmasked_fires_R8: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~mask) != '0) |-> irq_out);

endmodule

bind edge_irq_aggregator edge_irq_checker #(
    .NUM_LINES (NUM_LINES)
) u_checker (
    .clk      (clk),
    .rst      (rst),
    .mask     (mask_w),
    .ack      (ack_w),
    .edge_hit (edge_w),
    .pending  (pending_w),
    .irq_out  (irq_out)
);

// File: tb/test_edge_irq_aggregator.sv
module test_edge_irq_aggregator;

    localparam int N  = 76;
    localparam int NW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  gpio_in = '0;
    logic [7:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] rd;

    always #2 clk = ~clk;

    edge_irq_aggregator i_edge_irq_aggregator (
        .clk       (clk),
        .rst       (rst),
        .gpio_in   (gpio_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_line(input int n, input logic v);
        @(negedge clk);
        gpio_in[n] = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        for (int w = 0; w < NW; w++) begin
            rd_reg(8'(w*4), rd);
            check("R1 mask reset", rd, (w == NW-1) ? 'h0FFF : 'hFFFF);
            rd_reg(8'('h40 + w*4), rd);
            check("R1 type reset", rd, 0);
            rd_reg(8'('hC0 + w*4), rd);
            check("R1 status reset", rd, 0);
        end
        check("R1 irq reset", irq_out, 0);

        // R9 top-word padding on mask
        wr_reg(8'h10, 16'hFFFF);
        rd_reg(8'h10, rd);
        check("R9 mask pad bits", rd, 'h0FFF);

        // unmask all
        for (int w = 0; w < NW; w++) wr_reg(8'(w*4), 16'h0000);

        // R10 latency on line 0
        @(negedge clk); gpio_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 not yet pending", irq_out, 0);
        @(negedge clk);
        check("R10 pending on third edge", irq_out, 1);
        wr_reg(8'h28, 16'h0001);
        check("R6 ack clears line 0", irq_out, 0);
        set_line(0, 1'b0);

        // R2 / R4 rising sweep
        for (int n = 0; n < N; n++) begin
            set_line(n, 1'b1);
            rd_reg(8'('hC0 + (n/16)*4), rd);
            check("R2 R4 rising status word", rd, 1 << (n % 16));
            check("R8 irq high", irq_out, 1);
            wr_reg(8'('h28 + (n/16)*4), 16'(1 << (n % 16)));
            check("R6 ack clears", irq_out, 0);
            set_line(n, 1'b0);
            check("R2 falling ignored", irq_out, 0);
        end

        // R3 falling sweep
        for (int w = 0; w < NW; w++) wr_reg(8'('h40 + w*4), 16'hFFFF);
        rd_reg(8'h50, rd);
        check("R9 type pad bits", rd, 'h0FFF);
        @(negedge clk); gpio_in = '1;
        repeat (3) @(negedge clk);
        check("R3 rising ignored", irq_out, 0);
        for (int n = 0; n < N; n++) begin
            set_line(n, 1'b0);
            rd_reg(8'('hC0 + (n/16)*4), rd);
            check("R3 R4 falling status word", rd, 1 << (n % 16));
            wr_reg(8'('h28 + (n/16)*4), 16'(1 << (n % 16)));
            check("R6 ack clears falling", irq_out, 0);
            set_line(n, 1'b1);
            check("R3 rising ignored per line", irq_out, 0);
        end

        // R5 masking keeps pending
        wr_reg(8'h04, 16'h0010);
        set_line(20, 1'b0);
        check("R5 masked irq low", irq_out, 0);
        rd_reg(8'hC4, rd);
        check("R5 masked status", rd, 0);
        wr_reg(8'h04, 16'h0000);
        rd_reg(8'hC4, rd);
        check("R5 unmask reveals", rd, 'h0010);
        check("R8 irq after unmask", irq_out, 1);
        wr_reg(8'h2C, 16'h0000);
        rd_reg(8'hC4, rd);
        check("R6 ack zero no effect", rd, 'h0010);
        wr_reg(8'hC4, 16'h0000);
        rd_reg(8'hC4, rd);
        check("R9 status write ignored", rd, 'h0010);
        rd_reg(8'h2C, rd);
        check("R6 ack reads zero", rd, 0);
        wr_reg(8'h2C, 16'h0010);
        check("R6 ack clears line 20", irq_out, 0);
        rd_reg(8'hC2, rd);
        check("R4 unaligned reads zero", rd, 0);
        rd_reg(8'h14, rd);
        check("R4 unmapped reads zero", rd, 0);

        // R7 ack coincident with new edge on line 5
        for (int w = 0; w < NW; w++) wr_reg(8'('h40 + w*4), 16'h0000);
        @(negedge clk); gpio_in = '0;
        repeat (3) @(negedge clk);
        check("R2 falling ignored bulk", irq_out, 0);
        set_line(5, 1'b1);
        set_line(5, 1'b0);
        check("R7 line 5 pending", irq_out, 1);
        @(negedge clk); gpio_in[5] = 1'b1;
        repeat (2) @(negedge clk);
        reg_addr = 8'h28; reg_wdata = 16'h0020; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        rd_reg(8'hC0, rd);
        check("R7 edge wins over ack", rd, 'h0020);
        wr_reg(8'h28, 16'h0020);
        check("R7 later ack clears", irq_out, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule